// File: doc/BRIEF.md
# Sticky Limit-Violation Status Register

This block holds an 8-bit interrupt status byte for a hardware monitor. Seven of its bits capture out-of-limit events on monitored channels: four supply voltages and three temperatures. The comparisons against the high and low limits happen elsewhere; this block only receives one limit-exceeded condition flag per channel. A bit latches when its channel's condition is seen at a clock edge, and it stays latched after the condition goes away.

A read of the register clears a latched bit only when that channel's condition is no longer present. A fault that is still active survives the read, so software cannot lose an ongoing event by polling. The top bit summarises a second status register: it is the OR of that register's eight bits. That bit is not latched here, and reading this register does not clear it.

An interrupt request is raised whenever any bit of the byte is set. The register has no write path, so its bits are read-only from the bus.

Top module: `lvs_status_reg`

## Requirements
- R1: After reset, with the second-register input at zero, `status_o` reads 0x00 and `irq_o` is low.
- R2: When `cond_i[i]` is high at a rising clock edge, `status_o[i]` is 1 after that edge. The bit positions are: 0 the 2.5 V rail, 1 the CPU core rail, 2 the main supply rail, 3 the 5 V rail, 4 remote temperature 1, 5 local temperature, and 6 remote temperature 2.
- R3: A set channel bit stays 1 after its condition drops, for as long as no read strobe is seen.
- R4: When `rd_i` is high at an edge and `cond_i[i]` is low, `status_o[i]` is 0 after that edge.
- R5: When `rd_i` is high at an edge and `cond_i[i]` is high, `status_o[i]` stays 1 after that edge.
- R6: A condition that first rises in the same cycle as a read strobe leaves its bit set after the edge.
- R7: `status_o[7]` equals the OR of `aux_i[7:0]` in the same cycle. It is unaffected by read strobes and follows `aux_i` as soon as that input falls.
- R8: `irq_o` is high exactly when at least one bit of `status_o` is 1.
- R9: While `rd_i` is high, `status_o` shows the value from before the clear. Bits clear only at the edge that ends the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | 7 | Per-channel limit-exceeded condition flags |
| aux_i | input | 8 | Bits of the second status register |
| rd_i | input | 1 | Read strobe for this register's address, one cycle per read |
| status_o | output | 8 | Status byte: channel bits 6..0, summary bit 7 |
| irq_o | output | 1 | Interrupt request, OR of the status byte |

## Verification
The bench builds the block with its default parameters: seven channels, an eight-bit second register, and the combinational summary bit. With these values, every channel bit position can be walked one at a time. The clear-on-read rules (cleared, kept by an active fault, set by a fault that starts during the read) can each be reached directly. After the directed cases, a long run of random conditions, strobes and second-register values is compared on every clock against a behavioural model. The registered-summary variant, which adds one cycle of latency to bit 7, is not built by this bench.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
   // Channel positions inside the status byte (decoded by software)
   localparam int unsigned CH_RAIL_2V5   = 0;
   localparam int unsigned CH_RAIL_CORE  = 1;
   localparam int unsigned CH_RAIL_SUPP  = 2;
   localparam int unsigned CH_RAIL_5V    = 3;
   localparam int unsigned CH_TEMP_REM1  = 4;
   localparam int unsigned CH_TEMP_LOCAL = 5;
   localparam int unsigned CH_TEMP_REM2  = 6;
   localparam int unsigned CH_COUNT      = 7;

   // Next value of a sticky flag: a live condition wins over a clear
   function automatic logic sticky_next(input logic cur,
                                        input logic cond,
                                        input logic clr);
      return cond | (cur & ~clr);
   endfunction
endpackage

// File: rtl/lvs_sticky_cell.sv
module lvs_sticky_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,
   input  logic clr_i,
   output logic flag_o
);
   import lvs_pkg::*;

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= sticky_next(flag_q, cond_i, clr_i);
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/lvs_summary.sv
module lvs_summary #(
   parameter int unsigned AUX_W      = 8,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AUX_W-1:0] aux_i,
   output logic             any_o
);
   logic any_c;
   assign any_c = |aux_i;

   if (REGISTERED) begin : g_reg
      logic any_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) any_q <= 1'b0;
         else        any_q <= any_c;
      end
      assign any_o = any_q;
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk & rst_n;
      assign any_o = any_c;
   end
endmodule

// File: rtl/lvs_status_reg.sv
module lvs_status_reg #(
   parameter int unsigned NUM_CH      = 7,
   parameter int unsigned AUX_W       = 8,
   parameter bit          SUMMARY_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cond_i,
   input  logic [AUX_W-1:0]  aux_i,
   input  logic              rd_i,
   output logic [NUM_CH:0]   status_o,
   output logic              irq_o
);
   localparam int unsigned STAT_W = NUM_CH + 1;

   if (NUM_CH < 1 || NUM_CH > 31) begin : g_bad_ch
      $error("lvs_status_reg: NUM_CH must be 1..31");
   end
   if (AUX_W < 1 || AUX_W > 32) begin : g_bad_aux
      $error("lvs_status_reg: AUX_W must be 1..32");
   end

   logic [NUM_CH-1:0] flags;
   logic              summary;
   logic [STAT_W-1:0] stat;

   // One sticky cell per monitored channel; the read strobe is the clear
   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      lvs_sticky_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .cond_i (cond_i[g]),
         .clr_i  (rd_i),
         .flag_o (flags[g])
      );
   end

   lvs_summary #(
      .AUX_W      (AUX_W),
      .REGISTERED (SUMMARY_REG)
   ) u_summary (
      .clk   (clk),
      .rst_n (rst_n),
      .aux_i (aux_i),
      .any_o (summary)
   );

   assign stat     = {summary, flags};
   assign status_o = stat;
   assign irq_o    = |stat;
endmodule

// File: rtl/lvs_status_chk.sv
module lvs_status_chk #(
   parameter int unsigned NUM_CH      = 7,
   parameter int unsigned AUX_W       = 8,
   parameter bit          SUMMARY_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] cond_i,
   input logic [AUX_W-1:0]  aux_i,
   input logic              rd_i,
   input logic [NUM_CH:0]   status_o,
   input logic              irq_o
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
      // R2 and R6: a live condition sets the bit, read or not
      a_r2_set_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
         cond_i[g] |=> status_o[g]);
      // R3
      a_r3_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
         (!rd_i && status_o[g]) |=> status_o[g]);
      // R4
      a_r4_clear_inactive: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_i && !cond_i[g]) |=> !status_o[g]);
      // R2: no set without a condition
      a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         (!cond_i[g] && !status_o[g]) |=> !status_o[g]);
   end

   if (SUMMARY_REG) begin : g_sum_reg
      a_r7_summary: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> (status_o[NUM_CH] == $past(|aux_i)));
   end else begin : g_sum_comb
      a_r7_summary: assert property (@(posedge clk) disable iff (!rst_n)
         status_o[NUM_CH] == (|aux_i));
   end

   a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (|status_o));
endmodule

bind lvs_status_reg lvs_status_chk #(
   .NUM_CH      (NUM_CH),
   .AUX_W       (AUX_W),
   .SUMMARY_REG (SUMMARY_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cond_i   (cond_i),
   .aux_i    (aux_i),
   .rd_i     (rd_i),
   .status_o (status_o),
   .irq_o    (irq_o)
);

// File: tb/lvs_status_reg_tb.sv
module lvs_status_reg_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] cond_i = '0;
   logic [7:0] aux_i = '0;
   logic       rd_i = 1'b0;
   logic [7:0] status_o;
   logic       irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit model [7];

   always #5 clk = ~clk;

   lvs_status_reg u_dut (
      .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .aux_i(aux_i),
      .rd_i(rd_i), .status_o(status_o), .irq_o(irq_o)
   );

   function automatic logic [7:0] expect_byte(input logic [7:0] a);
      logic [7:0] e;
      e[7] = (a != 0);
      for (int i = 0; i < 7; i++) e[i] = model[i];
      return e;
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: status actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   // Called at a falling edge: drive, clock, update the model, compare
   task automatic step(input logic [6:0] c, input logic [7:0] a,
                       input logic r, input string tag);
      logic [7:0] exp;
      cond_i = c; aux_i = a; rd_i = r;
      #1;
      if (r) check8("R9 value before clear", status_o, expect_byte(a));
      @(posedge clk);
      for (int i = 0; i < 7; i++) begin
         if (c[i])  model[i] = 1'b1;
         else if (r) model[i] = 1'b0;
      end
      @(negedge clk);
      exp = expect_byte(a);
      check8(tag, status_o, exp);
      check1("R8 irq", irq_o, exp != 0);
   endtask

   initial begin
      for (int i = 0; i < 7; i++) model[i] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check8("R1 reset value", status_o, 8'h00);
      check1("R1 reset irq", irq_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1 after release", status_o, 8'h00);

      // Walk each channel bit position
      for (int i = 0; i < 7; i++) begin
         step(7'(1 << i), 8'h00, 1'b0, "R2 channel set");
         step(7'h00, 8'h00, 1'b0, "R3 sticky");
         step(7'h00, 8'h00, 1'b1, "R4 clear on read");
      end
      check8("R8 idle", status_o, 8'h00);

      // Active fault survives a read, inactive one clears
      step(7'h50, 8'h00, 1'b0, "R2 two channels");
      step(7'h10, 8'h00, 1'b1, "R5 active survives read");
      step(7'h00, 8'h00, 1'b0, "R3 sticky after drop");
      step(7'h00, 8'h00, 1'b1, "R4 clear after drop");

      // Condition rising in the read cycle
      step(7'h08, 8'h00, 1'b1, "R6 set during read");
      step(7'h00, 8'h00, 1'b1, "R4 later clear");

      // Summary bit
      step(7'h00, 8'h20, 1'b0, "R7 summary high");
      step(7'h00, 8'h20, 1'b1, "R7 read does not clear summary");
      step(7'h00, 8'h80, 1'b1, "R7 other aux bit");
      step(7'h00, 8'h00, 1'b0, "R7 summary follows aux low");
      check1("R8 irq low", irq_o, 1'b0);

      // Random phase against the model
      for (int n = 0; n < 3000; n++) begin
         logic [6:0] c;
         logic [7:0] a;
         logic       r;
         c = 7'($urandom) & 7'($urandom);
         a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
         r = ($urandom_range(0, 2) == 0);
         step(c, a, r, "R3/R4/R5 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule